// File: doc/BRIEF.md
# Asymmetric Line-Valid Detector

This block watches a set of serial receiver channels and reports, on one active-low flag, whether the attached cable looks detached. Each channel arrives as a single digital bit that an upstream comparator stage has already resolved: a 1 means the line currently sits at a legal signalling level, a 0 means it does not. An unconnected or grounded line shows up as 0.

The flag is deliberately lopsided. It drops to 0 only when every channel has read as not-valid for a long unbroken span of `ASSERT_CYCLES` clocks. It climbs back to 1 after a short span of `RELEASE_CYCLES` clocks during which at least one channel is valid. A power manager reads the flag to decide when the line interface can be shut down. The flag itself never alters any power state; it only reports.

A build-time parameter chooses how the two force outputs toward the powerdown controller are driven. In the tied variant, both outputs copy the flag, so a detached cable forces powerdown and a reattached cable forces power-on. In the pass-through variant, the outputs copy two host inputs, and the detector runs alongside them without affecting them.

Top module: `line_valid_detector`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `invalid_n_o` is 0. Both qualification counts restart from zero.
- R2: `invalid_n_o` falls from 1 to 0 at the (2 + `ASSERT_CYCLES`)-th rising edge after every bit of `ch_valid_i` has become 0, provided the bits stay 0 throughout. It does not fall earlier.
- R3: `invalid_n_o` rises from 0 to 1 at the (2 + `RELEASE_CYCLES`)-th rising edge after some bit of `ch_valid_i` has become 1, provided at least one bit stays 1 throughout. It does not rise earlier.
- R4: If any channel is seen valid while the flag is 1 and the fall count is running, the fall count restarts from zero. A later fall then needs a full `ASSERT_CYCLES` quiet span.
- R5: If all channels read invalid again before the rise count completes, the rise is cancelled and the flag stays 0. A later rise needs a full `RELEASE_CYCLES` valid span.
- R6: Bit k of `ch_valid_i` is 1 for a valid level on channel k and 0 for invalid, open or grounded. Any single channel, or any mix of channels, can release the flag.
- R7: With `TIE_FORCE` = 1, `force_on_o` and `force_off_n_o` both equal `invalid_n_o` in every cycle.
- R8: With `TIE_FORCE` = 0, `force_on_o` equals `host_force_on_i` and `force_off_n_o` equals `host_force_off_n_i`. The flag behaves exactly as in R2 to R5, whatever the host inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid_i | input | NUM_CH | Per-channel level-valid bits from the comparators (asynchronous) |
| host_force_on_i | input | 1 | Host force-on request, used only in the pass-through variant |
| host_force_off_n_i | input | 1 | Host active-low force-off request, used only in the pass-through variant |
| invalid_n_o | output | 1 | Active-low flag: 0 means no channel carries a valid level |
| force_on_o | output | 1 | Force-on drive toward the powerdown controller |
| force_off_n_o | output | 1 | Active-low force-off drive toward the powerdown controller |

## Verification
The stimulus holds single channels, channel pairs and all-quiet patterns for exactly the threshold length and for one cycle short of it. This separates a correct edge count from an off-by-one in either direction, and from a missing synchroniser stage. A short valid pulse placed inside a long quiet span shows whether the fall count restarts. A short valid burst that ends one cycle before the rise would complete shows whether the rise is cancelled rather than merely paused. A second instance in the pass-through variant is driven with changing host force values, which shows that the host values reach its force outputs and never reach its flag.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
   typedef enum logic {
      LINE_ABSENT  = 1'b0,
      LINE_PRESENT = 1'b1
   } line_state_e;

   function automatic int unsigned span_width(input int unsigned limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction
endpackage

// File: rtl/lvd_sync_bank.sv
module lvd_sync_bank #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lvd_sync_bank: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lvd_sync_bank: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lvd_span_counter.sv
module lvd_span_counter #(
   parameter int unsigned LIMIT = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic advance_i,
   output logic done_o,
   output logic [lvd_pkg::span_width(LIMIT)-1:0] count_o
);
   localparam int unsigned CW = lvd_pkg::span_width(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("lvd_span_counter: LIMIT must be at least 1");
   end

   logic [CW-1:0] count_q;

   assign done_o  = advance_i && (count_q == LAST);
   assign count_o = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count_q <= '0;
      else if (!advance_i)       count_q <= '0;
      else if (count_q == LAST)  count_q <= '0;
      else                       count_q <= count_q + 1'b1;
   end

   AST_SPAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= LAST);                                          // R2
   AST_SPAN_CLEARS_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !advance_i |=> (count_q == '0));                           // R4
endmodule

// File: rtl/line_valid_detector.sv
module line_valid_detector #(
   parameter int unsigned NUM_CH         = 5,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned ASSERT_CYCLES  = 30,
   parameter int unsigned RELEASE_CYCLES = 4,
   parameter bit          TIE_FORCE      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_valid_i,
   input  logic              host_force_on_i,
   input  logic              host_force_off_n_i,
   output logic              invalid_n_o,
   output logic              force_on_o,
   output logic              force_off_n_o
);
   import lvd_pkg::*;

   localparam int unsigned FALL_W = span_width(ASSERT_CYCLES);
   localparam int unsigned RISE_W = span_width(RELEASE_CYCLES);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("line_valid_detector: NUM_CH must be at least 1");
   end
   if (ASSERT_CYCLES < RELEASE_CYCLES) begin : g_bad_order
      $error("line_valid_detector: ASSERT_CYCLES must not be below RELEASE_CYCLES");
   end

   logic [NUM_CH-1:0] ch_sync;
   logic              any_valid;
   line_state_e       state_q;
   logic              fall_adv, rise_adv, fall_done, rise_done;
   logic [FALL_W-1:0] fall_cnt;
   logic [RISE_W-1:0] rise_cnt;

   lvd_sync_bank #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ch_valid_i),
      .sync_o  (ch_sync)
   );

   assign any_valid = |ch_sync;
   assign fall_adv  = (state_q == LINE_PRESENT) && !any_valid;
   assign rise_adv  = (state_q == LINE_ABSENT)  &&  any_valid;

   lvd_span_counter #(.LIMIT(ASSERT_CYCLES)) u_fall_span (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (fall_adv),
      .done_o    (fall_done),
      .count_o   (fall_cnt)
   );

   lvd_span_counter #(.LIMIT(RELEASE_CYCLES)) u_rise_span (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (rise_adv),
      .done_o    (rise_done),
      .count_o   (rise_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         state_q <= LINE_ABSENT;
      else if (fall_done) state_q <= LINE_ABSENT;
      else if (rise_done) state_q <= LINE_PRESENT;
   end

   assign invalid_n_o = (state_q == LINE_PRESENT);

   if (TIE_FORCE) begin : g_tied
      logic unused_host;
      assign unused_host   = host_force_on_i ^ host_force_off_n_i;
      assign force_on_o    = invalid_n_o;
      assign force_off_n_o = invalid_n_o;
   end else begin : g_host
      assign force_on_o    = host_force_on_i;
      assign force_off_n_o = host_force_off_n_i;
   end

   AST_FALL_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(invalid_n_o) |-> !$past(any_valid));                   // R2
   AST_RISE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(invalid_n_o) |-> $past(any_valid));                    // R3
   AST_FALL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      any_valid |=> (fall_cnt == '0));                             // R4
   AST_RISE_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      !any_valid |=> (rise_cnt == '0) && (invalid_n_o == 1'b0 || $past(invalid_n_o)));  // R5
endmodule

// File: tb/line_valid_detector_tb.sv
module line_valid_detector_tb;
   localparam time         CLK_PERIOD = 10ns;
   localparam int unsigned NCH  = 4;
   localparam int unsigned AC   = 12;
   localparam int unsigned RC   = 3;
   localparam int unsigned NVEC = 13;

   typedef struct packed {
      logic [3:0] pat;
      logic [7:0] hold;
      logic       exp;
      logic [3:0] req;
   } vec_t;

   // pattern, edges to hold, expected flag afterwards, requirement number
   localparam vec_t VECS [NVEC] = '{
      '{4'b0001, 8'd4,  1'b0, 4'd3},
      '{4'b0001, 8'd1,  1'b1, 4'd3},
      '{4'b0000, 8'd13, 1'b1, 4'd2},
      '{4'b0000, 8'd1,  1'b0, 4'd2},
      '{4'b1010, 8'd5,  1'b1, 4'd6},
      '{4'b0000, 8'd8,  1'b1, 4'd2},
      '{4'b0100, 8'd2,  1'b1, 4'd4},
      '{4'b0000, 8'd13, 1'b1, 4'd4},
      '{4'b0000, 8'd1,  1'b0, 4'd4},
      '{4'b0010, 8'd2,  1'b0, 4'd5},
      '{4'b0000, 8'd6,  1'b0, 4'd5},
      '{4'b0010, 8'd4,  1'b0, 4'd5},
      '{4'b0010, 8'd1,  1'b1, 4'd5}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] ch_valid = '0;
   logic           host_on = 1'b0;
   logic           host_off_n = 1'b0;
   logic           flag_t, fon_t, foff_t;
   logic           flag_h, fon_h, foff_h;
   int             n_checks = 0;
   int             n_fail = 0;
   bit             done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   line_valid_detector #(
      .NUM_CH(NCH), .SYNC_STAGES(2), .ASSERT_CYCLES(AC),
      .RELEASE_CYCLES(RC), .TIE_FORCE(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ch_valid_i(ch_valid),
      .host_force_on_i(host_on), .host_force_off_n_i(host_off_n),
      .invalid_n_o(flag_t), .force_on_o(fon_t), .force_off_n_o(foff_t)
   );

   line_valid_detector #(
      .NUM_CH(NCH), .SYNC_STAGES(2), .ASSERT_CYCLES(AC),
      .RELEASE_CYCLES(RC), .TIE_FORCE(1'b0)
   ) u_dut_host (
      .clk(clk), .rst_n(rst_n), .ch_valid_i(ch_valid),
      .host_force_on_i(host_on), .host_force_off_n_i(host_off_n),
      .invalid_n_o(flag_h), .force_on_o(fon_h), .force_off_n_o(foff_h)
   );

   function automatic string req_name(input logic [3:0] r);
      case (r)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         4'd7: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "flag in reset", flag_t, 1'b0);
      check("R7", "force_on tied in reset", fon_t, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         ch_valid   = VECS[i].pat;
         host_on    = i[0];
         host_off_n = i[1];
         repeat (int'(VECS[i].hold)) @(posedge clk);
         @(negedge clk);
         check(req_name(VECS[i].req), $sformatf("flag vec %0d", i), flag_t, VECS[i].exp);
         check("R7", $sformatf("force_on tied vec %0d", i), fon_t, VECS[i].exp);
         check("R7", $sformatf("force_off_n tied vec %0d", i), foff_t, VECS[i].exp);
         check("R8", $sformatf("host flag vec %0d", i), flag_h, VECS[i].exp);
         check("R8", $sformatf("host force_on vec %0d", i), fon_h, i[0]);
         check("R8", $sformatf("host force_off_n vec %0d", i), foff_h, i[1]);
      end

      // R1: reset in the middle of operation with flag high
      rst_n = 1'b0;
      #1;
      check("R1", "flag on async reset", flag_t, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      ch_valid = 4'b1000;
      // R3/R1: counts restarted, so a full release span is needed again
      repeat (2 + RC - 1) @(posedge clk);
      @(negedge clk);
      check("R1", "no early rise after reset", flag_t, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check("R6", "channel 3 alone releases", flag_t, 1'b1);

      finish_run();
   end
endmodule